// File: doc/BRIEF.md
# Linked Two-Road Signal Controller

This block drives the lamps of a crossing between a major road and a minor road. By default the major road has green. A sensor on the minor road reports waiting traffic. When the sensor is seen while the major road is green, the minor road gets green for a fixed number of clock cycles. After that interval the major road gets green again.

The design is split into two synchronous machines. A two-phase light sequencer owns the lamps. A separate interval timer counts the minor-road green time and acts as a hardware subroutine of the sequencer. The two machines are linked by a start request and a done flag. The sequencer raises the start request as a conditional output in the cycle in which it accepts a car. The timer raises done only in its last count state.

A parameter selects how the timer is built. The first variant is a sequencer that waits in an idle state until it is started. The second variant is a plain counter that runs only while the sequencer holds its enable high. Both variants give the same timing at the ports.

Top module: `linked_signal_ctrl`

## Requirements
- R1: While rst_ni is low, and with no clock edge needed, both timer styles show major green and minor red: maj_grn_o=1, maj_red_o=0, min_grn_o=0, min_red_o=1.
- R2: If car_i is high at a clock edge while the major road is green, the minor road is green after that edge.
- R3: If car_i is low at every edge while the major road is green, the lamps do not change.
- R4: Count from the edge that accepts a car. The minor road then stays green for exactly COUNT_LEN clock cycles (default 256), and the major road turns green again on edge COUNT_LEN.
- R5: car_i has no effect while the minor road is green. It neither restarts nor extends the interval.
- R6: The two roads never show green together, and each road always has exactly one of its red and green lamps lit.
- R7: If car_i is still high when the major road gets green back, the next edge starts a new full interval. The major road is then green for only one cycle.
- R8: TIMER_STYLE selects the timer variant. TMR_SUBR (0) is an idle-then-count sequencer that raises done only in its last count state and then goes idle. TMR_GATED (1) is a counter that advances only while enabled, raises done only in its last count while enabled, and wraps to zero. Both variants give identical lamp timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| car_i | input | 1 | Minor-road car sensor, active high |
| maj_grn_o | output | 1 | Major-road green lamp |
| maj_red_o | output | 1 | Major-road red lamp |
| min_grn_o | output | 1 | Minor-road green lamp |
| min_red_o | output | 1 | Minor-road red lamp |

## Verification
Both timer styles run side by side on the same sensor waveform. The waveform has several parts:
- A quiet sensor, which separates holding green from spurious switching.
- A single-cycle request, which shows that the request is latched.
- A sensor pulse late in the interval, which would expose any restart or extension.
- A sensor held high through the end of the interval, which must give a one-cycle major green followed by a second full interval. In the gated counter this also shows the wrap back to zero.

The minor-green run lengths are measured on every phase, which separates an off-by-one interval from a correct one. A reset pulse in the middle of an interval checks that the asynchronous return to major green happens at once.

// File: rtl/sig_pkg.sv
package sig_pkg;
  typedef enum logic {PH_MAJ = 1'b0, PH_MIN = 1'b1} phase_e;
  typedef enum logic {TMR_SUBR = 1'b0, TMR_GATED = 1'b1} tmr_style_e;
endpackage

// File: rtl/light_seq.sv
module light_seq
  import sig_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   car_i,
  input  logic   done_i,
  output logic   start_o,
  output logic   run_o,
  output phase_e phase_o,
  output logic   maj_grn_o,
  output logic   maj_red_o,
  output logic   min_grn_o,
  output logic   min_red_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    start_o = 1'b0;
    unique case (phase_q)
      PH_MAJ: if (car_i) begin
        start_o = 1'b1;  // conditional output, same edge as the move
        phase_d = PH_MIN;
      end
      PH_MIN: if (done_i) phase_d = PH_MAJ;
      default: phase_d = PH_MAJ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) phase_q <= PH_MAJ;
    else         phase_q <= phase_d;

  assign run_o     = (phase_q == PH_MIN);
  assign phase_o   = phase_q;
  assign maj_grn_o = (phase_q == PH_MAJ);
  assign maj_red_o = (phase_q == PH_MIN);
  assign min_grn_o = (phase_q == PH_MIN);
  assign min_red_o = (phase_q == PH_MAJ);

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MAJ && car_i) |=> (phase_q == PH_MIN));
  assert_hold_maj_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MAJ && !car_i) |=> (phase_q == PH_MAJ));
  assert_hold_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MIN && !done_i) |=> (phase_q == PH_MIN));
  assert_one_green_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(maj_grn_o && min_grn_o) && (maj_grn_o ^ maj_red_o) && (min_grn_o ^ min_red_o));
endmodule

// File: rtl/timer_subr.sv
module timer_subr #(
  parameter int COUNT_LEN = 256,
  localparam int CW = $clog2(COUNT_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(COUNT_LEN - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end

  assign done_o = busy_q && (cnt_q == LAST);

  assert_no_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
  assert_idle_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
  assert_idle_waits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> !busy_q);
endmodule

// File: rtl/timer_gated.sv
module timer_gated #(
  parameter int COUNT_LEN = 256,
  localparam int CW = $clog2(COUNT_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(COUNT_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt_q <= '0;
    else if (en_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  assign done_o = en_i && (cnt_q == LAST);

  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cnt_q == '0));
  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/linked_signal_ctrl.sv
module linked_signal_ctrl
  import sig_pkg::*;
#(
  parameter int         COUNT_LEN   = 256,
  parameter tmr_style_e TIMER_STYLE = TMR_SUBR,
  localparam int LW = $clog2(COUNT_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic car_i,
  output logic maj_grn_o,
  output logic maj_red_o,
  output logic min_grn_o,
  output logic min_red_o
);
  logic   start_w, run_w, done_w;
  phase_e phase_w;

  light_seq u_seq (
    .clk_i, .rst_ni, .car_i,
    .done_i   (done_w),
    .start_o  (start_w),
    .run_o    (run_w),
    .phase_o  (phase_w),
    .maj_grn_o, .maj_red_o, .min_grn_o, .min_red_o
  );

  generate
    if (TIMER_STYLE == TMR_SUBR) begin : g_subr
      timer_subr #(.COUNT_LEN(COUNT_LEN)) u_tmr (
        .clk_i, .rst_ni, .start_i(start_w), .done_o(done_w)
      );
    end else begin : g_gated
      timer_gated #(.COUNT_LEN(COUNT_LEN)) u_tmr (
        .clk_i, .rst_ni, .en_i(run_w), .done_o(done_w)
      );
    end
  endgenerate

  // minor-green run length, kept only for the interval check
  logic [LW-1:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        len_q <= '0;
    else if (min_grn_o) len_q <= len_q + 1'b1;
    else                len_q <= '0;

  assert_interval_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(min_grn_o) |-> (len_q == LW'(COUNT_LEN)));
  assert_done_only_min_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w |-> (phase_w == PH_MIN));
  assert_no_start_in_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |-> !start_w);
endmodule

// File: tb/sim_linked_signal_ctrl.sv
module sim_linked_signal_ctrl;
  import sig_pkg::*;
  localparam int N = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0;
  logic mg0, mr0, ng0, nr0, mg1, mr1, ng1, nr1;
  int checks = 0, errors = 0;
  int rl0 = 0, rl1 = 0;
  bit overlap = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  linked_signal_ctrl #(.COUNT_LEN(N), .TIMER_STYLE(TMR_SUBR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .car_i(car),
    .maj_grn_o(mg0), .maj_red_o(mr0), .min_grn_o(ng0), .min_red_o(nr0));
  linked_signal_ctrl #(.COUNT_LEN(N), .TIMER_STYLE(TMR_GATED)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .car_i(car),
    .maj_grn_o(mg1), .maj_red_o(mr1), .min_grn_o(ng1), .min_red_o(nr1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {car, expected minor green, req number, edges to apply}
  localparam int NV = 11;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd3, 16'd5},    // R3 quiet sensor
    {1'b1, 1'b1, 4'd2, 16'd1},    // R2 accept
    {1'b0, 1'b1, 4'd4, 16'd254},  // R4 edge 254 still minor
    {1'b1, 1'b1, 4'd5, 16'd1},    // R5 car in R ignored
    {1'b0, 1'b0, 4'd4, 16'd1},    // R4 edge 256 back to major
    {1'b0, 1'b0, 4'd3, 16'd3},    // R3
    {1'b1, 1'b1, 4'd2, 16'd1},    // R2
    {1'b1, 1'b1, 4'd5, 16'd255},  // R5 held car, edge 255 still minor
    {1'b1, 1'b0, 4'd4, 16'd1},    // R4 edge 256 major
    {1'b1, 1'b1, 4'd7, 16'd1},    // R7 one major cycle then minor
    {1'b0, 1'b0, 4'd7, 16'd256}   // R7 second full interval, R8 wrap
  };

  // phase-length and overlap monitor, sampled off the active edge
  always @(negedge clk) begin
    if ((mg0 && ng0) || (mg1 && ng1) || !(mg0 ^ mr0) || !(ng0 ^ nr0)
        || !(mg1 ^ mr1) || !(ng1 ^ nr1)) overlap = 1'b1;
    if (!rst_n) begin
      rl0 = 0; rl1 = 0;
    end else begin
      if (ng0) rl0++;
      else if (rl0 != 0) begin chk(rl0 == N, "R4 subr length", rl0, N); rl0 = 0; end
      if (ng1) rl1++;
      else if (rl1 != 0) begin chk(rl1 == N, "R4/R8 gated length", rl1, N); rl1 = 0; end
    end
  end

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5;
    // R1 lamps during reset
    chk({mg0, mr0, ng0, nr0} == 4'b1001, "R1 subr reset lamps", {mg0, mr0, ng0, nr0}, 4'b1001);
    chk({mg1, mr1, ng1, nr1} == 4'b1001, "R1 gated reset lamps", {mg1, mr1, ng1, nr1}, 4'b1001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      car = VEC[i][21];
      repeat (int'(VEC[i][15:0])) @(negedge clk);
      chk(ng0 == VEC[i][20], $sformatf("R%0d vec %0d subr", VEC[i][19:16], i), ng0, VEC[i][20]);
      chk(ng1 == VEC[i][20], $sformatf("R%0d/R8 vec %0d gated", VEC[i][19:16], i), ng1, VEC[i][20]);
    end

    // R1 asynchronous reset in the middle of an interval
    car = 1'b1;
    @(negedge clk);
    car = 1'b0;
    repeat (10) @(negedge clk);
    chk(ng0 && ng1, "R2 minor before reset", {ng0, ng1}, 2'b11);
    rst_n = 1'b0;
    #1;
    chk({mg0, mr0, ng0, nr0} == 4'b1001, "R1 subr async reset", {mg0, mr0, ng0, nr0}, 4'b1001);
    chk({mg1, mr1, ng1, nr1} == 4'b1001, "R1 gated async reset", {mg1, mr1, ng1, nr1}, 4'b1001);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // full interval after reset: timers must restart from zero (R4, R8)
    car = 1'b1;
    @(negedge clk);
    car = 1'b0;
    repeat (N - 1) @(negedge clk);
    chk(ng0 && ng1, "R4 edge N-1 still minor", {ng0, ng1}, 2'b11);
    @(negedge clk);
    chk(mg0 && mg1, "R4/R8 edge N major", {mg0, mg1}, 2'b11);
    repeat (2) @(negedge clk);

    chk(!overlap, "R6 lamp exclusivity", overlap, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule